// File: doc/BRIEF.md
# SPI Chip-Select Timing Controller

This block sequences the slave-select lines of a simple SPI master. Software programs a 32-bit control word holding a gap length (the number of idle SCLK periods forced after each frame), a late-select flag for the highest-numbered select line, and a local enable bit. A separate global enable register is the master enable for transmission. A write-only "queue" bit in the control word decides whether the local enable is copied into the global enable.

A write to the transmit buffer starts a frame if the block is enabled and idle. The gap length and the late-select flag are snapshotted at that moment, together with the chosen select line, so control writes made during a frame do not disturb it. Each frame runs through four phases, each counted in SCLK periods: a one-period lead, a fixed-length shift phase of `FRAME_BITS` periods, a one-period trail, and then the gap of 0 to 3 periods. The serial datapath is not part of this block. An internal divider makes one SCLK period every `SCLK_DIV` clock cycles.

Top module: `spi_cs_timer`

## Requirements
- R1: After reset, `reg_rdata` is 0, `xfer_en` is 0, `busy` is 0 and every `sel_n` line is high.
- R2: `reg_rdata` returns the gap field at bits [5:4], the late-select flag at bit 8 and the local enable at bit 15. Bit 14 (queue) and all other bits always read 0, whatever was written.
- R3: A global-enable write sets `xfer_en` to `glob_wdata`. A control write with bit 14 = 0 leaves `xfer_en` unchanged, whatever the value of bit 15.
- R4: A control write with bit 14 = 1 copies bit 15 into `xfer_en` on the next cycle. If both kinds of write occur in the same cycle, the global-enable write wins.
- R5: While `busy` is high, any write that would clear `xfer_en` is ignored, so the running frame completes.
- R6: A `txbuf_wr` is ignored while `xfer_en` is 0 and while `busy` is high. No frame starts.
- R7: An accepted `txbuf_wr` raises `busy` from the next cycle. `busy` stays high for (FRAME_BITS+2+G)*SCLK_DIV cycles, where G is the gap field (encodings 0..3 give 0..3 idle periods).
- R8: The line chosen by `tx_sel` goes low in the same cycle that `busy` rises. It stays low for (FRAME_BITS+2)*SCLK_DIV cycles. At most one line is low at a time, and only while `busy` is high.
- R9: With the late-select flag set and line NUM_SEL-1 chosen, that line goes low one SCLK period later than normal and releases at the normal time. The flag has no effect on the other lines.
- R10: The gap field and the late-select flag are captured on each accepted `txbuf_wr`. Control writes during a frame affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| glob_wr | input | 1 | Global enable write strobe |
| glob_wdata | input | 1 | Global enable write value |
| txbuf_wr | input | 1 | Transmit buffer write (frame start request) |
| tx_sel | input | SEL_W | Select line used by the requested frame |
| xfer_en | output | 1 | Effective transmit/receive enable |
| busy | output | 1 | Frame in progress, lead through gap |
| sel_n | output | NUM_SEL | Active-low slave-select lines |

## Verification
The bench changes the control word in the middle of a frame. A design that does not snapshot the control word would stretch the gap or delay the select line of the frame already running. The bench also tries to clear the enable during a frame through both paths. A design without the busy guard would drop `xfer_en` in the middle of a frame. The late-select flag is tested on the highest line and on a lower one. A design that decodes the wrong line would shift the wrong line, or shorten a normal line by one SCLK period. Extra `txbuf_wr` pulses are sent while disabled and while busy. If those were accepted, a spurious frame would follow, visible as `busy` rising again.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    localparam int CTL_W     = 32;
    localparam int F_GAP_LO  = 4;
    localparam int F_LATE    = 8;
    localparam int F_QUEUE   = 14;
    localparam int F_LOC_EN  = 15;
    localparam logic [CTL_W-1:0] RD_MASK =
        (CTL_W'(3) << F_GAP_LO) | (CTL_W'(1) << F_LATE) | (CTL_W'(1) << F_LOC_EN);

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_SHIFT,
        SEQ_TRAIL,
        SEQ_GAP
    } seq_state_e;

    typedef struct packed {
        logic [1:0] gap;
        logic       late;
        logic       loc_en;
    } ctl_reg_t;

    typedef struct packed {
        logic [1:0] gap;
        logic       late;
    } frame_cfg_t;

    function automatic ctl_reg_t unpack_ctl(input logic [CTL_W-1:0] w);
        ctl_reg_t r;
        r.gap    = w[F_GAP_LO +: 2];
        r.late   = w[F_LATE];
        r.loc_en = w[F_LOC_EN];
        return r;
    endfunction

    function automatic logic [CTL_W-1:0] pack_ctl(input ctl_reg_t r);
        logic [CTL_W-1:0] w;
        w = '0;
        w[F_GAP_LO +: 2] = r.gap;
        w[F_LATE]        = r.late;
        w[F_LOC_EN]      = r.loc_en;
        return w;
    endfunction

endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
    import spi_cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    input  logic             glob_wr,
    input  logic             glob_wdata,
    input  logic             busy,
    output ctl_reg_t         ctl,
    output logic [CTL_W-1:0] reg_rdata,
    output logic             xfer_en
);

    logic en_req;
    logic en_next;

    always_comb begin
        en_req = xfer_en;
        if (glob_wr)
            en_req = glob_wdata;
        else if (reg_wr && reg_wdata[F_QUEUE])
            en_req = reg_wdata[F_LOC_EN];
        // a running frame may not lose its enable
        en_next = (busy && !en_req) ? xfer_en : en_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            xfer_en <= 1'b0;
        end else begin
            if (reg_wr)
                ctl <= unpack_ctl(reg_wdata);
            xfer_en <= en_next;
        end
    end

    assign reg_rdata = pack_ctl(ctl);

endmodule

// File: rtl/spi_cs_sclkdiv.sv
module spi_cs_sclkdiv #(
    parameter int SCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    localparam int CW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCLK_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int NUM_SEL    = 8,
    parameter int SEL_W      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txbuf_wr,
    input  logic               xfer_en,
    input  logic [SEL_W-1:0]   tx_sel,
    input  ctl_reg_t           ctl,
    input  logic               tick,
    output logic               busy,
    output logic [NUM_SEL-1:0] sel_n
);

    localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [BW-1:0]    LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [SEL_W-1:0] LATE_IDX = SEL_W'(NUM_SEL - 1);

    seq_state_e       state;
    frame_cfg_t       snap;
    logic [SEL_W-1:0] idx;
    logic [BW-1:0]    bit_cnt;
    logic [1:0]       gap_cnt;
    logic             start;
    logic             late_line;
    logic             line_on;

    assign start = (state == SEQ_IDLE) && txbuf_wr && xfer_en;
    assign busy  = (state != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            snap    <= '0;
            idx     <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state     <= SEQ_LEAD;
                        snap.gap  <= ctl.gap;
                        snap.late <= ctl.late;
                        idx       <= tx_sel;
                    end
                end
                SEQ_LEAD: begin
                    if (tick) begin
                        state   <= SEQ_SHIFT;
                        bit_cnt <= '0;
                    end
                end
                SEQ_SHIFT: begin
                    if (tick) begin
                        if (bit_cnt == LAST_BIT)
                            state <= SEQ_TRAIL;
                        else
                            bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                SEQ_TRAIL: begin
                    if (tick) begin
                        gap_cnt <= '0;
                        state   <= (snap.gap == 2'd0) ? SEQ_IDLE : SEQ_GAP;
                    end
                end
                SEQ_GAP: begin
                    if (tick) begin
                        if (gap_cnt == snap.gap - 2'd1)
                            state <= SEQ_IDLE;
                        else
                            gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign late_line = snap.late && (idx == LATE_IDX);
    assign line_on   = ((state == SEQ_LEAD) && !late_line) ||
                       (state == SEQ_SHIFT) || (state == SEQ_TRAIL);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel_n[i] = !(line_on && (idx == SEL_W'(i)));
    end

endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer
    import spi_cs_pkg::*;
#(
    parameter int SCLK_DIV   = 4,
    parameter int FRAME_BITS = 8,
    parameter int NUM_SEL    = 8,
    localparam int SEL_W     = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               glob_wr,
    input  logic               glob_wdata,
    input  logic               txbuf_wr,
    input  logic [SEL_W-1:0]   tx_sel,
    output logic               xfer_en,
    output logic               busy,
    output logic [NUM_SEL-1:0] sel_n
);

    ctl_reg_t ctl;
    logic     tick;

    spi_cs_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .glob_wr   (glob_wr),
        .glob_wdata(glob_wdata),
        .busy      (busy),
        .ctl       (ctl),
        .reg_rdata (reg_rdata),
        .xfer_en   (xfer_en)
    );

    spi_cs_sclkdiv #(.SCLK_DIV(SCLK_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .tick(tick)
    );

    spi_cs_seq #(
        .FRAME_BITS(FRAME_BITS),
        .NUM_SEL   (NUM_SEL),
        .SEL_W     (SEL_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .txbuf_wr(txbuf_wr),
        .xfer_en (xfer_en),
        .tx_sel  (tx_sel),
        .ctl     (ctl),
        .tick    (tick),
        .busy    (busy),
        .sel_n   (sel_n)
    );

endmodule

// File: rtl/spi_cs_timer_chk.sv
module spi_cs_timer_chk
    import spi_cs_pkg::*;
#(
    parameter int NUM_SEL = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic               glob_wr,
    input logic               txbuf_wr,
    input logic               xfer_en,
    input logic               busy,
    input logic [NUM_SEL-1:0] sel_n
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~RD_MASK) == 32'd0);

    assert_en_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!glob_wr && !(reg_wr && reg_wdata[F_QUEUE])) |=> $stable(xfer_en));

    assert_no_clear_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && xfer_en) |=> xfer_en);

    assert_no_start_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !xfer_en) |=> !busy);

    assert_busy_from_write_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(txbuf_wr));

    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sel_n));

    assert_sel_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (~&sel_n) |-> busy);

endmodule

bind spi_cs_timer spi_cs_timer_chk #(.NUM_SEL(NUM_SEL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .glob_wr  (glob_wr),
    .txbuf_wr (txbuf_wr),
    .xfer_en  (xfer_en),
    .busy     (busy),
    .sel_n    (sel_n)
);

// File: tb/spi_cs_timer_test.sv
module spi_cs_timer_test;

    localparam int DIV = 4;
    localparam int FB  = 8;
    localparam int NS  = 8;
    localparam int SW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          glob_wr = 1'b0;
    logic          glob_wdata = 1'b0;
    logic          txbuf_wr = 1'b0;
    logic [SW-1:0] tx_sel = '0;
    logic          xfer_en;
    logic          busy;
    logic [NS-1:0] sel_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_cs_timer #(.SCLK_DIV(DIV), .FRAME_BITS(FB), .NUM_SEL(NS)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .glob_wr(glob_wr), .glob_wdata(glob_wdata),
        .txbuf_wr(txbuf_wr), .tx_sel(tx_sel), .xfer_en(xfer_en),
        .busy(busy), .sel_n(sel_n)
    );

    // {write data, expected readback, expected enable}
    localparam logic [64:0] VEC [8] = '{
        {32'h0000_0000, 32'h0000_0000, 1'b0},
        {32'hFFFF_FFFF, 32'h0000_8130, 1'b1},
        {32'h0000_0010, 32'h0000_0010, 1'b1},
        {32'h0000_0020, 32'h0000_0020, 1'b1},
        {32'h0000_0100, 32'h0000_0100, 1'b1},
        {32'h0000_4000, 32'h0000_0000, 1'b0},
        {32'h0000_8000, 32'h0000_8000, 1'b0},
        {32'hFFFF_BECF, 32'h0000_8000, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic glob_write(input logic v);
        @(negedge clk); glob_wr = 1'b1; glob_wdata = v;
        @(negedge clk); glob_wr = 1'b0;
    endtask

    // mid_kind: 0 none, 1 control write, 2 global write, 3 extra txbuf_wr
    task automatic run_frame(input int line, input int mid_kind, input logic [31:0] mid_data,
                             output int busy_cnt, output int low_cnt,
                             output int first_low, output int other_low);
        busy_cnt = 0; low_cnt = 0; first_low = -1; other_low = 0;
        @(negedge clk); txbuf_wr = 1'b1; tx_sel = SW'(line);
        @(negedge clk); txbuf_wr = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (i == 5) begin
                case (mid_kind)
                    1: begin reg_wr = 1'b1; reg_wdata = mid_data; end
                    2: begin glob_wr = 1'b1; glob_wdata = mid_data[0]; end
                    3: txbuf_wr = 1'b1;
                    default: ;
                endcase
            end
            if (i == 6) begin reg_wr = 1'b0; glob_wr = 1'b0; txbuf_wr = 1'b0; end
            if (!busy) break;
            busy_cnt++;
            if (!sel_n[line]) begin
                low_cnt++;
                if (first_low < 0) first_low = i;
            end
            for (int k = 0; k < NS; k++)
                if (k != line && !sel_n[k]) other_low = 1;
            @(negedge clk);
        end
    endtask

    task automatic idle_busy(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        check(req, seen, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b, l, f, o;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", int'(reg_rdata), 0);
        check("R1 xfer_en", int'(xfer_en), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 sel_n", int'(sel_n), 255);

        // R2 R3 R4 readback and enable vectors
        foreach (VEC[i]) begin
            reg_write(VEC[i][64:33]);
            check("R2 readback", int'(reg_rdata), int'(VEC[i][32:1]));
            check("R3/R4 enable", int'(xfer_en), int'(VEC[i][0]));
        end

        // R3 global enable path
        glob_write(1'b1);
        check("R3 glob set", int'(xfer_en), 1);
        glob_write(1'b0);
        check("R3 glob clear", int'(xfer_en), 0);

        // R4 global write wins over queue write in the same cycle
        @(negedge clk); glob_wr = 1'b1; glob_wdata = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h0000_C000;
        @(negedge clk); glob_wr = 1'b0; reg_wr = 1'b0;
        check("R4 priority", int'(xfer_en), 0);

        // R6 start while disabled is ignored
        @(negedge clk); txbuf_wr = 1'b1;
        @(negedge clk); txbuf_wr = 1'b0;
        check("R6 disabled start", int'(busy), 0);
        idle_busy("R6 disabled start later", 2 * DIV);

        // R7 R8 gap 0, line 2
        reg_write(32'h0000_C000);
        check("R4 queue enable", int'(xfer_en), 1);
        run_frame(2, 0, 0, b, l, f, o);
        check("R7 busy gap0", b, (FB + 2) * DIV);
        check("R8 low len", l, (FB + 2) * DIV);
        check("R8 first low", f, 0);
        check("R8 other lines", o, 0);

        // R7 gap 3, line 7 normal
        reg_write(32'h0000_0030);
        run_frame(7, 0, 0, b, l, f, o);
        check("R7 busy gap3", b, (FB + 5) * DIV);
        check("R8 low len line7", l, (FB + 2) * DIV);

        // R9 late flag on line 7, gap 2
        reg_write(32'h0000_0120);
        run_frame(7, 0, 0, b, l, f, o);
        check("R7 busy gap2", b, (FB + 4) * DIV);
        check("R9 late low len", l, (FB + 1) * DIV);
        check("R9 late first low", f, DIV);

        // R9 late flag on another line has no effect
        run_frame(3, 0, 0, b, l, f, o);
        check("R9 line3 low len", l, (FB + 2) * DIV);
        check("R9 line3 first low", f, 0);

        // R10 snapshot: gap 1 normal, mid-frame write of gap 3 + late
        reg_write(32'h0000_0010);
        run_frame(7, 1, 32'h0000_0130, b, l, f, o);
        check("R10 busy keeps old gap", b, (FB + 3) * DIV);
        check("R10 keeps normal select", f, 0);
        run_frame(7, 0, 0, b, l, f, o);
        check("R10 next gap", b, (FB + 5) * DIV);
        check("R10 next late", f, DIV);

        // R5 clear attempts during a frame
        reg_write(32'h0000_0000);
        run_frame(1, 2, 32'h0, b, l, f, o);
        check("R5 glob clear ignored", int'(xfer_en), 1);
        check("R5 frame completes", b, (FB + 2) * DIV);
        run_frame(1, 1, 32'h0000_4000, b, l, f, o);
        check("R5 queue clear ignored", int'(xfer_en), 1);

        // R6 start while busy is ignored
        run_frame(4, 3, 0, b, l, f, o);
        check("R6 busy frame len", b, (FB + 2) * DIV);
        idle_busy("R6 busy start", 2 * DIV);

        // R3 clear when idle takes effect
        glob_write(1'b0);
        check("R3 idle clear", int'(xfer_en), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule